// File: doc/BRIEF.md
# Run-Length Configuration Bit Expander

This block sits between a byte source holding a compressed configuration image and a serial configuration sequencer. It reads bytes over a ready/valid channel and throws them away until it sees the start marker of the payload. It then sends a fixed sixteen-bit sync word, one bit per handshake. After that it expands every payload byte into a run of ones or zeros, following a run-length code that is split by the parameter `MAX_ONES`.

Bits leave one at a time on a second ready/valid channel, and the downstream side may stall that channel at any time. One code byte can expand into hundreds of bits, so the block accepts no further byte until the current code has been fully emitted. The source marks the final payload byte with `in_last`. Once the final bit of that byte has been taken downstream, `eos` rises and stays high until reset. From then on the block accepts nothing and emits nothing.

Top module: `cfg_rle_expander`

## Requirements
- R1: While reset is applied and right after it, `out_valid` and `eos` are 0 and `in_ready` is 1, so the block is scanning.
- R2: Before the start marker, every accepted byte is discarded and no bit is emitted. The marker is a byte of 0xFF accepted directly before a byte whose bits [7:4] are 0x3. Payload begins with the byte after that second marker byte.
- R3: Once the marker has been found, the block emits the 16 bits of 0xFF20, most significant bit first, before any payload bit. It accepts no byte while these bits are being emitted.
- R4: Payload code 0 emits no bits.
- R5: A payload code n with 1 <= n <= MAX_ONES (default 226) emits n ones and then one zero.
- R6: Payload code MAX_ONES+1 emits MAX_ONES ones and no zero.
- R7: A payload code n with MAX_ONES+2 <= n <= 254 emits n-(MAX_ONES+2) zeros and then one one. Code MAX_ONES+2 therefore emits a single one.
- R8: Payload code 255 emits a single one.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_bit` does not change on the next cycle.
- R10: `in_ready` is 0 in every cycle in which `out_valid` is 1. No new code byte is taken before the previous one has been fully emitted.
- R11: `eos` rises in the cycle after the handshake that takes the last bit of the byte accepted with `in_last` = 1. If that byte is code 0, `eos` rises in the cycle after the byte itself is accepted. `eos` then stays 1, and `in_ready` and `out_valid` stay 0, until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Byte offered on `in_data` |
| in_data | input | 8 | Compressed stream byte |
| in_last | input | 1 | Marks the final payload byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| out_valid | output | 1 | Bit offered on `out_bit` |
| out_bit | output | 1 | Serial configuration bit |
| out_ready | input | 1 | Downstream takes the bit this cycle |
| eos | output | 1 | End of stream, sticky until reset |

## Verification
The assertions assume that the downstream side follows the ready/valid rule and that a stalled bit is simply held until it is taken. They also assume that `in_last` appears only on a payload byte, never during the marker scan, and that exactly one stream is sent per reset, because `eos` locks the block. The bench drives `in_last` only on the final payload byte and applies a fresh reset before each stream. It changes `out_ready` only between clock edges, following a pseudo-random pattern mixed with long stall windows, so the hold rule is exercised while the sync word is being sent and while runs are being expanded.

// File: rtl/cre_pkg.sv
package cre_pkg;
  localparam int CODE_W = 8;

  typedef enum logic [1:0] {
    ST_SCAN = 2'd0,
    ST_SYNC = 2'd1,
    ST_PAY  = 2'd2,
    ST_DONE = 2'd3
  } cre_state_e;

  // Expansion plan for one code byte: a run of run_bit repeated run_len
  // times, then an optional single terminator bit.
  typedef struct packed {
    logic [CODE_W-1:0] run_len;
    logic              run_bit;
    logic              term_en;
    logic              term_bit;
  } cre_plan_t;
endpackage

// File: rtl/cre_preamble.sv
module cre_preamble #(
  parameter int          CODE_W    = 8,
  parameter logic [7:0]  MARK_BYTE = 8'hFF,
  parameter logic [3:0]  TAG_NIB   = 4'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] data,
  output logic              hit
);
  logic prev_mark_q, prev_mark_d;

  always_comb begin
    prev_mark_d = prev_mark_q;
    if (en) prev_mark_d = (data == MARK_BYTE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_mark_q <= 1'b0;
    else        prev_mark_q <= prev_mark_d;
  end

  assign hit = en && prev_mark_q && (data[CODE_W-1 -: 4] == TAG_NIB);
endmodule

// File: rtl/cre_decode.sv
module cre_decode
  import cre_pkg::*;
#(
  parameter int MAX_ONES = 226
) (
  input  logic [CODE_W-1:0] code,
  output cre_plan_t         plan
);
  localparam logic [CODE_W-1:0] ONES_TOP  = CODE_W'(MAX_ONES);
  localparam logic [CODE_W-1:0] ONES_OPEN = CODE_W'(MAX_ONES + 1);
  localparam logic [CODE_W-1:0] ZERO_BASE = CODE_W'(MAX_ONES + 2);
  localparam logic [CODE_W-1:0] CODE_MAX  = {CODE_W{1'b1}};

  always_comb begin
    plan = '0;
    if (code == '0) begin
      plan = '0;
    end else if (code <= ONES_TOP) begin
      plan.run_len  = code;
      plan.run_bit  = 1'b1;
      plan.term_en  = 1'b1;
      plan.term_bit = 1'b0;
    end else if (code == ONES_OPEN) begin
      plan.run_len  = ONES_TOP;
      plan.run_bit  = 1'b1;
    end else if (code == CODE_MAX) begin
      plan.term_en  = 1'b1;
      plan.term_bit = 1'b1;
    end else begin
      plan.run_len  = code - ZERO_BASE;
      plan.run_bit  = 1'b0;
      plan.term_en  = 1'b1;
      plan.term_bit = 1'b1;
    end
  end
endmodule

// File: rtl/cre_run_gen.sv
module cre_run_gen
  import cre_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  cre_plan_t plan,
  input  logic      ready,
  output logic      active,
  output logic      bit_o,
  output logic      final_bit
);
  logic [CODE_W-1:0] cnt_q, cnt_d;
  logic              rbit_q, rbit_d;
  logic              tpend_q, tpend_d;
  logic              tbit_q, tbit_d;
  logic              fire;

  assign active    = (cnt_q != '0) || tpend_q;
  assign bit_o     = (cnt_q != '0) ? rbit_q : tbit_q;
  assign fire      = active && ready;
  assign final_bit = fire && ((cnt_q == CODE_W'(1) && !tpend_q) || (cnt_q == '0));

  always_comb begin
    cnt_d   = cnt_q;
    rbit_d  = rbit_q;
    tpend_d = tpend_q;
    tbit_d  = tbit_q;
    if (load) begin
      cnt_d   = plan.run_len;
      rbit_d  = plan.run_bit;
      tpend_d = plan.term_en;
      tbit_d  = plan.term_bit;
    end else if (fire) begin
      if (cnt_q != '0) cnt_d   = cnt_q - CODE_W'(1);
      else             tpend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rbit_q  <= 1'b0;
      tpend_q <= 1'b0;
      tbit_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      rbit_q  <= rbit_d;
      tpend_q <= tpend_d;
      tbit_q  <= tbit_d;
    end
  end
endmodule

// File: rtl/cfg_rle_expander.sv
module cfg_rle_expander
  import cre_pkg::*;
#(
  parameter int                  MAX_ONES = 226,
  parameter int                  SYNC_LEN = 16,
  parameter logic [SYNC_LEN-1:0] SYNC_PAT = 16'hFF20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              out_valid,
  output logic              out_bit,
  input  logic              out_ready,
  output logic              eos
);
  localparam int SCNT_W = $clog2(SYNC_LEN);

  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cre_state_e         state_q, state_d;
  logic [SCNT_W-1:0]  sync_cnt_q, sync_cnt_d;
  logic               last_pend_q, last_pend_d;
  logic               in_fire, scan_en, load, hit;
  logic               gen_active, gen_bit, gen_final, gen_ready;
  cre_plan_t          plan;

  assign in_ready  = (state_q == ST_SCAN) || ((state_q == ST_PAY) && !gen_active);
  assign in_fire   = in_valid && in_ready;
  assign scan_en   = in_fire && (state_q == ST_SCAN);
  assign load      = in_fire && (state_q == ST_PAY);
  assign gen_ready = out_ready && (state_q == ST_PAY);
  assign out_valid = (state_q == ST_SYNC) || ((state_q == ST_PAY) && gen_active);
  assign out_bit   = (state_q == ST_SYNC) ? SYNC_PAT[SCNT_W'(SYNC_LEN-1) - sync_cnt_q] : gen_bit;
  assign eos       = (state_q == ST_DONE);

  cre_preamble #(.CODE_W(CODE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .en    (scan_en),
    .data  (in_data),
    .hit   (hit)
  );

  cre_decode #(.MAX_ONES(MAX_ONES)) u_dec (
    .code (in_data),
    .plan (plan)
  );

  cre_run_gen u_gen (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .load      (load),
    .plan      (plan),
    .ready     (gen_ready),
    .active    (gen_active),
    .bit_o     (gen_bit),
    .final_bit (gen_final)
  );

  always_comb begin
    state_d     = state_q;
    sync_cnt_d  = sync_cnt_q;
    last_pend_d = last_pend_q;
    unique case (state_q)
      ST_SCAN: begin
        if (hit) begin
          state_d    = ST_SYNC;
          sync_cnt_d = '0;
        end
      end
      ST_SYNC: begin
        if (out_ready) begin
          if (sync_cnt_q == SCNT_W'(SYNC_LEN-1)) state_d = ST_PAY;
          else sync_cnt_d = sync_cnt_q + SCNT_W'(1);
        end
      end
      ST_PAY: begin
        if (load && in_last) begin
          if (plan.run_len == '0 && !plan.term_en) state_d = ST_DONE;
          else last_pend_d = 1'b1;
        end
        if (gen_final && last_pend_q) state_d = ST_DONE;
      end
      default: state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      state_q     <= ST_SCAN;
      sync_cnt_q  <= '0;
      last_pend_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      sync_cnt_q  <= sync_cnt_d;
      last_pend_q <= last_pend_d;
    end
  end
endmodule

// File: rtl/cre_checker.sv
module cre_checker #(
  parameter int                  SYNC_LEN = 16,
  parameter logic [SYNC_LEN-1:0] SYNC_PAT = 16'hFF20
) (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic out_valid,
  input logic out_bit,
  input logic out_ready,
  input logic eos
);
  localparam int SW = $clog2(SYNC_LEN);
  localparam int CW = $clog2(SYNC_LEN + 1);

  logic [CW-1:0] seen_q;
  logic [SW-1:0] sidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (out_valid && out_ready && seen_q < CW'(SYNC_LEN)) seen_q <= seen_q + CW'(1);
  end

  assign sidx = SW'(SYNC_LEN-1) - seen_q[SW-1:0];

  AST_SYNC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen_q < CW'(SYNC_LEN)) |-> (out_bit == SYNC_PAT[sidx])); // R3

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit))); // R9

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R10

  AST_EOS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    eos |=> eos); // R11

  AST_EOS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    eos |-> (!in_ready && !out_valid)); // R11
endmodule

bind cfg_rle_expander cre_checker #(.SYNC_LEN(SYNC_LEN), .SYNC_PAT(SYNC_PAT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_bit   (out_bit),
  .out_ready (out_ready),
  .eos       (eos)
);

// File: tb/tb_cfg_rle_expander.sv
module tb_cfg_rle_expander;
  localparam int MAXO = 226;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_last = 1'b0;
  logic       in_ready, out_valid, out_bit, eos;
  logic       out_ready = 1'b0;

  int checks = 0;
  int failures = 0;
  int ready_mode = 0;  // 0 pseudo-random, 1 always ready, 2 stalled
  logic [7:0] lfsr = 8'hA5;
  logic q_bit[$];
  string q_tag[$];
  logic prev_stall = 1'b0;
  logic prev_bit = 1'b0;

  always #5 clk = ~clk;

  cfg_rle_expander dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid),
    .out_bit(out_bit), .out_ready(out_ready), .eos(eos)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic b, input string tag);
    q_bit.push_back(b);
    q_tag.push_back(tag);
  endtask

  task automatic push_sync();
    logic [15:0] w = 16'hFF20;
    for (int i = 15; i >= 0; i--) push(w[i], "R3");
  endtask

  task automatic push_code(input int code);
    if (code == 0) begin
      // R4: nothing expected
    end else if (code <= MAXO) begin
      repeat (code) push(1'b1, "R5");
      push(1'b0, "R5");
    end else if (code == MAXO + 1) begin
      repeat (MAXO) push(1'b1, "R6");
    end else if (code == 255) begin
      push(1'b1, "R8");
    end else begin
      repeat (code - (MAXO + 2)) push(1'b0, "R7");
      push(1'b1, "R7");
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the handshake.
  task automatic send(input logic [7:0] b, input logic last);
    in_valid = 1'b1;
    in_data  = b;
    in_last  = last;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_last = 1'b0;
    q_bit.delete();
    q_tag.delete();
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(eos == 1'b0, "R1", "eos in reset", int'(eos), 0);
    check(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Scoreboard monitor: sets out_ready between edges, then checks the handshake.
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = (ready_mode == 1) ? 1'b1 :
                  (ready_mode == 2) ? 1'b0 : (lfsr[0] | lfsr[2]);
      #1;
      if (rst_n) begin
        if (prev_stall)  // R9
          check(out_valid && (out_bit == prev_bit), "R9", "bit held under stall",
                int'(out_bit), int'(prev_bit));
        if (out_valid && in_ready)  // R10
          check(1'b0, "R10", "in_ready while emitting", 1, 0);
        if (out_valid && out_ready) begin
          if (q_bit.size() == 0) begin
            check(1'b0, "R2", "unexpected output bit", int'(out_bit), -1);
          end else begin
            automatic logic eb = q_bit.pop_front();
            automatic string et = q_tag.pop_front();
            check(out_bit == eb, et, "output bit", int'(out_bit), int'(eb));
            check(eos == 1'b0, "R11", "eos before final bit", int'(eos), 0);
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_bit   = out_bit;
      end else begin
        prev_stall = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired R11 actual=%0d expected=%0d", q_bit.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // Stream A: scan noise, sync, every code class, ends on a nonzero code
    do_reset();
    ready_mode = 0;
    send(8'h12, 1'b0);   // R2 noise
    send(8'hFF, 1'b0);
    send(8'h20, 1'b0);   // R2 upper nibble 2: no marker
    send(8'h3F, 1'b0);   // R2 nibble 3 without 0xFF before it
    send(8'hFF, 1'b0);
    send(8'hFF, 1'b0);
    push_sync();         // R3
    send(8'h35, 1'b0);   // completes marker
    #1;
    check(in_ready == 1'b0, "R3", "in_ready during sync", int'(in_ready), 0);
    begin
      automatic int codes[10] = '{3, 0, 1, 226, 227, 228, 229, 254, 255, 5};
      foreach (codes[i]) begin
        push_code(codes[i]);
        send(8'(codes[i]), (i == 9));
      end
    end
    while (q_bit.size() != 0) @(negedge clk);
    #1;
    check(eos == 1'b1, "R11", "eos after final bit", int'(eos), 1);
    in_valid = 1'b1;
    in_data  = 8'h07;
    repeat (5) begin
      @(negedge clk);
      #1;
      check(!in_ready && !out_valid && eos, "R11", "quiet after eos",
            int'({in_ready, out_valid, eos}), 1);
    end
    in_valid = 1'b0;

    // Stream B: marker FF 31, stall during sync, last byte is code 0
    do_reset();
    send(8'hFF, 1'b0);
    push_sync();
    send(8'h31, 1'b0);
    ready_mode = 2;
    repeat (8) @(negedge clk);
    #1;
    check(out_valid == 1'b1, "R9", "valid held through stall", int'(out_valid), 1);
    ready_mode = 0;
    push_code(2);
    send(8'd2, 1'b0);
    push_code(228);      // R7 single one
    send(8'd228, 1'b0);
    check(eos == 1'b0, "R11", "eos before last byte", int'(eos), 0);
    send(8'd0, 1'b1);    // R4 code 0 as final byte
    #1;
    check(eos == 1'b1, "R11", "eos after code 0 last", int'(eos), 1);
    check(q_bit.size() == 0, "R4", "pending bits at code 0 end", q_bit.size(), 0);
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule